// File: doc/BRIEF.md
# Transmit Session Controller with Ownership Lock

This block sits between an on-chip bus receive queue and the transmit side of a UDP/IP engine. Every bus transfer starts with an address word, marked by the address-valid flag, and continues with data words. The top four bits of the first data word select a command. A configuration command stores a timeout, a destination IP address, a pair of UDP ports and a return address for acknowledges. It also binds the controller to the bus address the configuration arrived on. Once the controller is bound, transmit-start commands from that address stream their payload to the UDP/IP side as 16-bit words. A release command from the same address unbinds the controller.

Traffic from any other address is consumed and thrown away and never reaches the UDP/IP side. Where a return address is known, the controller tells the sender with a negative acknowledge. Acknowledge words leave through a one-word write port that honours a full flag. The UDP/IP side reads with an edge-sensitive read strobe. A bus read is held off whenever an acknowledge is waiting and the write port is full.

Top module: `txs_ctrl`

## Requirements
- R1: The command sits in data-word bits [31:28]. Code 0 is configuration, 1 is transmit start and 2 is release. Code 3 is a receive configuration meant for another block, and its 4 words are skipped without effect. Any other code is one word and is ignored. A data word that arrives while an address word is expected is discarded.
- R2: A configuration is 4 words. Word 0 holds the timeout in bits [27:0]. Word 1 holds the destination IP. Word 2 holds the destination port in [31:16] and the source port in [15:0]. Word 3 is the acknowledge address. The configuration is taken when the controller is unbound or when it comes from the bound address. Taking it drives these values on the outputs, binds the controller to the sender's address, and writes the word 0x58000000 to the acknowledge address.
- R3: A configuration from a non-bound address while the controller is bound changes no stored value. It writes the negative acknowledge 0x5F000000 to the stored acknowledge address.
- R4: A transmit-start header carries the byte length in bits [27:17]. When it is accepted, new_tx_o is high for exactly one cycle, and tx_len_o shows the length. tx_len_o and the header outputs stay stable until the first 16-bit word is read.
- R5: An accepted transmit consumes ceil(len/4) payload words and delivers ceil(len/2) 16-bit words. Within each bus word the low half goes first.
- R6: A transmit start that arrives while unbound or from a non-bound address consumes and drops its ceil(len/4) payload words. It raises neither new_tx_o nor tx_valid_o. It sends 0x5F000000 to the acknowledge address if one has ever been stored, and otherwise sends nothing.
- R7: A release word (code 2) from the bound address unbinds the controller. A release from any other address has no effect.
- R8: Only a rising edge of tx_re_i while tx_valid_o is high consumes a 16-bit word. A read strobe that is held high consumes nothing more.
- R9: While an acknowledge is waiting and ack_full_i is high, bus_re_o is low and ack_we_o is low. The acknowledge stays held until the port has room.
- R10: After reset the controller is unbound and idle: bus_re_o is high and tx_valid_o, new_tx_o and ack_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_av_i | input | 1 | Current bus word is an address word |
| bus_data_i | input | BUS_W | Bus word from the receive queue |
| bus_empty_i | input | 1 | Receive queue has no word |
| bus_re_o | output | 1 | Read enable to the receive queue |
| ack_we_o | output | 1 | Acknowledge write strobe |
| ack_addr_o | output | BUS_W | Destination address of the acknowledge |
| ack_data_o | output | BUS_W | Acknowledge word, code in the top byte |
| ack_full_i | input | 1 | Acknowledge port cannot accept a word |
| tx_data_o | output | BUS_W/2 | 16-bit payload word to UDP/IP |
| tx_valid_o | output | 1 | tx_data_o holds a word |
| tx_re_i | input | 1 | Edge-sensitive read strobe from UDP/IP |
| new_tx_o | output | 1 | One-cycle start-of-transmit strobe |
| tx_len_o | output | LEN_W | Transmit length in bytes |
| dst_ip_o | output | BUS_W | Stored destination IP |
| dst_port_o | output | BUS_W/2 | Stored destination UDP port |
| src_port_o | output | BUS_W/2 | Stored source UDP port |
| timeout_o | output | BUS_W-4 | Stored timeout value |

## Verification
The assertions check several rules on every cycle. The read strobe never advances the output word while it stays high, and a word is loaded only into an empty output stage. A waiting acknowledge is never overwritten and is held while the port is full. A stalled bus read never moves the command parser, the new-transmit strobe lasts one cycle, and payload is only loaded while bound. The bench scenarios cover the rest: the payload order and word counts for odd and even lengths, acceptance and rejection of configurations, the choice between a negative acknowledge and silence, command skipping, and release and rebinding.

// File: rtl/txs_pkg.sv
package txs_pkg;
   localparam int CMD_W  = 4;
   localparam int CODE_W = 8;

   typedef enum logic [2:0] {
      ST_ADDR,
      ST_HDR,
      ST_CFG,
      ST_PAY,
      ST_SKIP
   } txs_state_e;

   localparam logic [CMD_W-1:0] CMD_TX_CFG  = 4'd0;
   localparam logic [CMD_W-1:0] CMD_TX_GO   = 4'd1;
   localparam logic [CMD_W-1:0] CMD_RELEASE = 4'd2;
   localparam logic [CMD_W-1:0] CMD_RX_CFG  = 4'd3;

   localparam logic [CODE_W-1:0] CODE_CFG_OK = 8'h58;
   localparam logic [CODE_W-1:0] CODE_NACK   = 8'h5F;

   localparam int CFG_EXTRA_WORDS = 3;
endpackage

// File: rtl/txs_half_ser.sv
module txs_half_ser #(
   parameter int HALF_W    = 16,
   parameter bit EDGE_READ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [2*HALF_W-1:0] word_i,
   input  logic                two_i,
   output logic                ready_o,
   output logic [HALF_W-1:0]   data_o,
   output logic                valid_o,
   input  logic                rd_i
);
   logic [2*HALF_W-1:0] buf_q;
   logic                full_q, sel_q, two_q;
   logic                take;

   generate
      if (HALF_W < 1) begin : g_bad_w
         $error("txs_half_ser: HALF_W must be positive");
      end
      if (EDGE_READ) begin : g_edge
         logic rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= 1'b0;
            else        rd_q <= rd_i;
         end
         assign take = rd_i & ~rd_q & full_q;
      end else begin : g_level
         assign take = rd_i & full_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         sel_q  <= 1'b0;
         two_q  <= 1'b0;
      end else if (load_i) begin
         buf_q  <= word_i;
         full_q <= 1'b1;
         sel_q  <= 1'b0;
         two_q  <= two_i;
      end else if (take) begin
         if (!sel_q && two_q) sel_q  <= 1'b1;
         else                 full_q <= 1'b0;
      end
   end

   assign ready_o = ~full_q;
   assign valid_o = full_q;
   assign data_o  = sel_q ? buf_q[2*HALF_W-1:HALF_W] : buf_q[HALF_W-1:0];

   // R8: a read strobe that stays high does not move to another word
   a_r8_held_read_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && rd_i && $past(rd_i) && EDGE_READ) |=> ($stable(data_o) && valid_o));

   // R5: a new bus word only enters an empty output stage
   a_r5_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !full_q);
endmodule

// File: rtl/txs_ack_port.sv
module txs_ack_port #(
   parameter int BUS_W  = 32,
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_i,
   input  logic [BUS_W-1:0]  addr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              full_i,
   output logic              we_o,
   output logic [BUS_W-1:0]  addr_o,
   output logic [BUS_W-1:0]  data_o,
   output logic              pend_o
);
   localparam int PAD_W = BUS_W - CODE_W;

   generate
      if (PAD_W < 1) begin : g_bad_code
         $error("txs_ack_port: CODE_W must be narrower than BUS_W");
      end
   endgenerate

   logic              pend_q;
   logic [BUS_W-1:0]  addr_q;
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
         code_q <= '0;
      end else if (send_i) begin
         pend_q <= 1'b1;
         addr_q <= addr_i;
         code_q <= code_i;
      end else if (pend_q && !full_i) begin
         pend_q <= 1'b0;
      end
   end

   assign we_o   = pend_q & ~full_i;
   assign addr_o = addr_q;
   assign data_o = {code_q, {PAD_W{1'b0}}};
   assign pend_o = pend_q;

   // R9: a waiting acknowledge is never replaced while it cannot leave
   a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      send_i |-> !(pend_q && full_i));

   // R9: a blocked acknowledge stays intact until the port has room
   a_r9_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && full_i && !send_i) |=> (pend_q && $stable(addr_q) && $stable(code_q)));
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
   import txs_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int LEN_W     = 11,
   parameter bit EDGE_READ = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_av_i,
   input  logic [BUS_W-1:0]       bus_data_i,
   input  logic                   bus_empty_i,
   output logic                   bus_re_o,
   output logic                   ack_we_o,
   output logic [BUS_W-1:0]       ack_addr_o,
   output logic [BUS_W-1:0]       ack_data_o,
   input  logic                   ack_full_i,
   output logic [BUS_W/2-1:0]     tx_data_o,
   output logic                   tx_valid_o,
   input  logic                   tx_re_i,
   output logic                   new_tx_o,
   output logic [LEN_W-1:0]       tx_len_o,
   output logic [BUS_W-1:0]       dst_ip_o,
   output logic [BUS_W/2-1:0]     dst_port_o,
   output logic [BUS_W/2-1:0]     src_port_o,
   output logic [BUS_W-CMD_W-1:0] timeout_o
);
   localparam int HALF_W  = BUS_W / 2;
   localparam int TMO_W   = BUS_W - CMD_W;
   localparam int LEN_TOP = TMO_W - 1;
   localparam int LEN_BOT = TMO_W - LEN_W;

   generate
      if (BUS_W % 2 != 0 || BUS_W < 32) begin : g_bad_bus
         $error("txs_ctrl: BUS_W must be even and at least 32");
      end
      if (LEN_BOT < 0) begin : g_bad_len
         $error("txs_ctrl: LEN_W does not fit below the command field");
      end
   endgenerate

   txs_state_e        state_q;
   logic [BUS_W-1:0]  addr_q, lock_addr_q, ack_dst_q, ip_q;
   logic [HALF_W-1:0] dport_q, sport_q;
   logic [TMO_W-1:0]  tmo_q;
   logic [LEN_W-1:0]  len_q, cnt_q, half_q;
   logic              locked_q, have_ack_q, cfg_ok_q, new_q;

   logic              take, stall, owner, ack_pend;
   logic [CMD_W-1:0]  cmd;
   logic [LEN_W-1:0]  hdr_len, n_words, n_halves;
   logic [LEN_W:0]    len_ext;
   logic              ser_ready, ser_load, ser_two;
   logic              send;
   logic [BUS_W-1:0]  send_addr;
   logic [CODE_W-1:0] send_code;

   assign cmd      = bus_data_i[BUS_W-1 -: CMD_W];
   assign hdr_len  = bus_data_i[LEN_TOP:LEN_BOT];
   assign len_ext  = {1'b0, hdr_len};
   assign n_words  = LEN_W'((len_ext + (LEN_W+1)'(3)) >> 2);
   assign n_halves = LEN_W'((len_ext + (LEN_W+1)'(1)) >> 1);
   assign owner    = locked_q && (addr_q == lock_addr_q);
   assign stall    = ack_pend & ack_full_i;
   assign take     = bus_re_o & ~bus_empty_i;
   assign ser_load = (state_q == ST_PAY) && take;
   assign ser_two  = half_q > LEN_W'(1);

   always_comb begin
      if (state_q == ST_PAY) bus_re_o = !stall && ser_ready && (cnt_q != '0);
      else                   bus_re_o = !stall;
   end

   always_comb begin
      send      = 1'b0;
      send_addr = ack_dst_q;
      send_code = CODE_NACK;
      if (take) begin
         if (state_q == ST_CFG && cnt_q == LEN_W'(1)) begin
            if (cfg_ok_q) begin
               send      = 1'b1;
               send_addr = bus_data_i;
               send_code = CODE_CFG_OK;
            end else begin
               send = have_ack_q;
            end
         end else if (state_q == ST_HDR && !bus_av_i && cmd == CMD_TX_GO && !owner) begin
            send = have_ack_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_ADDR;
         addr_q      <= '0;
         lock_addr_q <= '0;
         ack_dst_q   <= '0;
         ip_q        <= '0;
         dport_q     <= '0;
         sport_q     <= '0;
         tmo_q       <= '0;
         len_q       <= '0;
         cnt_q       <= '0;
         half_q      <= '0;
         locked_q    <= 1'b0;
         have_ack_q  <= 1'b0;
         cfg_ok_q    <= 1'b0;
         new_q       <= 1'b0;
      end else begin
         new_q <= 1'b0;
         unique case (state_q)
            ST_ADDR: begin
               if (take && bus_av_i) begin
                  addr_q  <= bus_data_i;
                  state_q <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (take && bus_av_i) begin
                  addr_q <= bus_data_i;
               end else if (take) begin
                  unique case (cmd)
                     CMD_TX_CFG: begin
                        cfg_ok_q <= !locked_q || owner;
                        if (!locked_q || owner) tmo_q <= bus_data_i[TMO_W-1:0];
                        cnt_q   <= LEN_W'(CFG_EXTRA_WORDS);
                        state_q <= ST_CFG;
                     end
                     CMD_TX_GO: begin
                        cnt_q <= n_words;
                        if (owner) begin
                           new_q   <= 1'b1;
                           len_q   <= hdr_len;
                           half_q  <= n_halves;
                           state_q <= ST_PAY;
                        end else begin
                           state_q <= (n_words == '0) ? ST_ADDR : ST_SKIP;
                        end
                     end
                     CMD_RELEASE: begin
                        if (owner) locked_q <= 1'b0;
                        state_q <= ST_ADDR;
                     end
                     CMD_RX_CFG: begin
                        cnt_q   <= LEN_W'(CFG_EXTRA_WORDS);
                        state_q <= ST_SKIP;
                     end
                     default: state_q <= ST_ADDR;
                  endcase
               end
            end
            ST_CFG: begin
               if (take) begin
                  cnt_q <= cnt_q - LEN_W'(1);
                  if (cnt_q == LEN_W'(3)) begin
                     if (cfg_ok_q) ip_q <= bus_data_i;
                  end else if (cnt_q == LEN_W'(2)) begin
                     if (cfg_ok_q) begin
                        dport_q <= bus_data_i[BUS_W-1:HALF_W];
                        sport_q <= bus_data_i[HALF_W-1:0];
                     end
                  end else begin
                     if (cfg_ok_q) begin
                        ack_dst_q   <= bus_data_i;
                        have_ack_q  <= 1'b1;
                        locked_q    <= 1'b1;
                        lock_addr_q <= addr_q;
                     end
                     state_q <= ST_ADDR;
                  end
               end
            end
            ST_PAY: begin
               if (take) begin
                  cnt_q  <= cnt_q - LEN_W'(1);
                  half_q <= half_q - (ser_two ? LEN_W'(2) : LEN_W'(1));
               end else if (cnt_q == '0 && ser_ready) begin
                  state_q <= ST_ADDR;
               end
            end
            ST_SKIP: begin
               if (take) begin
                  cnt_q <= cnt_q - LEN_W'(1);
                  if (cnt_q == LEN_W'(1)) state_q <= ST_ADDR;
               end
            end
            default: state_q <= ST_ADDR;
         endcase
      end
   end

   txs_half_ser #(
      .HALF_W   (HALF_W),
      .EDGE_READ(EDGE_READ)
   ) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ser_load),
      .word_i (bus_data_i),
      .two_i  (ser_two),
      .ready_o(ser_ready),
      .data_o (tx_data_o),
      .valid_o(tx_valid_o),
      .rd_i   (tx_re_i)
   );

   txs_ack_port #(
      .BUS_W (BUS_W),
      .CODE_W(CODE_W)
   ) u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .send_i(send),
      .addr_i(send_addr),
      .code_i(send_code),
      .full_i(ack_full_i),
      .we_o  (ack_we_o),
      .addr_o(ack_addr_o),
      .data_o(ack_data_o),
      .pend_o(ack_pend)
   );

   assign new_tx_o   = new_q;
   assign tx_len_o   = len_q;
   assign dst_ip_o   = ip_q;
   assign dst_port_o = dport_q;
   assign src_port_o = sport_q;
   assign timeout_o  = tmo_q;

   // R4: the start strobe lasts exactly one cycle
   a_r4_new_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      new_tx_o |=> !new_tx_o);

   // R6: payload reaches the output stage only while bound
   a_r6_stream_only_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ser_load |-> locked_q);

   // R9: a stalled read leaves the command parser where it is
   a_r9_stall_freezes_parser: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && state_q != ST_PAY) |=> $stable(state_q));
endmodule

// File: tb/tb_txs_ctrl.sv
module tb_txs_ctrl;
   localparam int PERIOD = 10;
   localparam int BUS_W  = 32;
   localparam int LEN_W  = 11;
   localparam logic [31:0] LOCK_A  = 32'h0123_4567;
   localparam logic [31:0] OTHER_A = 32'h1234_5678;
   localparam logic [31:0] ACK_A   = 32'h0082_FAAC;
   localparam logic [31:0] ACK_B   = 32'h00AA_0000;
   localparam logic [31:0] NEW_A   = 32'h0BEE_F000;

   // vector: {legal, length[10:0], tag[7:0]}
   localparam int NVEC = 6;
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b1, 11'd107, 8'd1},
      {1'b1, 11'd12,  8'd2},
      {1'b0, 11'd12,  8'd3},
      {1'b1, 11'd1,   8'd4},
      {1'b1, 11'd6,   8'd5},
      {1'b1, 11'd0,   8'd6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   logic              bus_av_i = 1'b0;
   logic [BUS_W-1:0]  bus_data_i = '0;
   logic              bus_empty_i = 1'b1;
   logic              bus_re_o;
   logic              ack_we_o;
   logic [BUS_W-1:0]  ack_addr_o, ack_data_o;
   logic              ack_full_i = 1'b0;
   logic [15:0]       tx_data_o;
   logic              tx_valid_o;
   logic              tx_re_i;
   logic              new_tx_o;
   logic [LEN_W-1:0]  tx_len_o;
   logic [BUS_W-1:0]  dst_ip_o;
   logic [15:0]       dst_port_o, src_port_o;
   logic [27:0]       timeout_o;

   txs_ctrl #(.BUS_W(BUS_W), .LEN_W(LEN_W), .EDGE_READ(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .bus_av_i(bus_av_i), .bus_data_i(bus_data_i), .bus_empty_i(bus_empty_i),
      .bus_re_o(bus_re_o),
      .ack_we_o(ack_we_o), .ack_addr_o(ack_addr_o), .ack_data_o(ack_data_o),
      .ack_full_i(ack_full_i),
      .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_re_i(tx_re_i),
      .new_tx_o(new_tx_o), .tx_len_o(tx_len_o), .dst_ip_o(dst_ip_o),
      .dst_port_o(dst_port_o), .src_port_o(src_port_o), .timeout_o(timeout_o)
   );

   int checks = 0;
   int errors = 0;
   int ack_n = 0, new_n = 0, cap_n = 0;
   logic [31:0] ack_addr_last = '0, ack_data_last = '0;
   logic [LEN_W-1:0] new_len_last = '0;
   logic [15:0] cap [256];
   bit rd_en = 1'b1;
   bit man_re = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor and UDP/IP-side reader, acting just after each falling edge
   initial begin
      tx_re_i = 1'b0;
      forever begin
         @(negedge clk);
         #1;
         if (new_tx_o) begin
            new_n++;
            new_len_last = tx_len_o;
         end
         if (ack_we_o) begin
            ack_n++;
            ack_addr_last = ack_addr_o;
            ack_data_last = ack_data_o;
         end
         if (rd_en) begin
            if (tx_valid_o && !tx_re_i) begin
               if (cap_n < 256) cap[cap_n] = tx_data_o;
               cap_n++;
               tx_re_i = 1'b1;
            end else begin
               tx_re_i = 1'b0;
            end
         end else begin
            tx_re_i = man_re;
         end
      end
   end

   task automatic put(input bit av, input logic [31:0] d);
      @(negedge clk);
      bus_av_i    = av;
      bus_data_i  = d;
      bus_empty_i = 1'b0;
      #2;
      while (!bus_re_o) begin
         @(negedge clk);
         #2;
      end
      @(posedge clk);
      @(negedge clk);
      bus_empty_i = 1'b1;
      bus_av_i    = 1'b0;
   endtask

   function automatic logic [31:0] hdr(input logic [3:0] c, input int len);
      return {c, 11'(len), 17'b0};
   endfunction

   task automatic send_cfg(input logic [31:0] src, input logic [27:0] tmo,
                           input logic [31:0] ip, input logic [31:0] ports,
                           input logic [31:0] ackaddr);
      put(1'b1, src);
      put(1'b0, {4'h0, tmo});
      put(1'b0, ip);
      put(1'b0, ports);
      put(1'b0, ackaddr);
   endtask

   task automatic send_start(input logic [31:0] src, input int len, input int tag);
      put(1'b1, src);
      put(1'b0, hdr(4'h1, len));
      for (int k = 0; k < (len + 3) / 4; k++)
         put(1'b0, {16'(tag*256 + 2*k + 1), 16'(tag*256 + 2*k)});
   endtask

   task automatic settle(input int target);
      for (int i = 0; i < 400 && cap_n < target; i++) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   initial begin
      #(PERIOD*100000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int base, n0, a0, bad, len, tag, exph;
      bit legal;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R10: reset state
      chk(bus_re_o == 1'b1, "R10 bus_re", bus_re_o, 1);
      chk(tx_valid_o == 1'b0 && new_tx_o == 1'b0 && ack_we_o == 1'b0, "R10 idle outputs",
          {tx_valid_o, new_tx_o, ack_we_o}, 0);

      // R6: start while unbound and no ack address known -> silent drop
      base = cap_n; n0 = new_n; a0 = ack_n;
      send_start(OTHER_A, 8, 50);
      settle(base);
      chk(cap_n == base && new_n == n0, "R6 unbound drop", cap_n - base + new_n - n0, 0);
      chk(ack_n == a0, "R6 no ack without address", ack_n - a0, 0);

      // R1: stray data word while waiting for an address is discarded
      put(1'b0, 32'h1000_0000);

      // R2: configuration binds and acknowledges
      a0 = ack_n;
      send_cfg(LOCK_A, 28'h000_1234, 32'hACDC_ABBA, 32'h0101_AAAA, ACK_A);
      repeat (3) @(negedge clk);
      chk(ack_n == a0 + 1, "R2 ack count", ack_n - a0, 1);
      chk(ack_addr_last == ACK_A, "R2 ack address", ack_addr_last, ACK_A);
      chk(ack_data_last == 32'h5800_0000, "R2 ack word", ack_data_last, 32'h5800_0000);
      chk(dst_ip_o == 32'hACDC_ABBA, "R2 dst ip", dst_ip_o, 32'hACDC_ABBA);
      chk(dst_port_o == 16'h0101 && src_port_o == 16'hAAAA, "R2 ports",
          {dst_port_o, src_port_o}, 32'h0101_AAAA);
      chk(timeout_o == 28'h000_1234, "R2 timeout", timeout_o, 28'h1234);

      // R3: configuration from another address while bound
      a0 = ack_n;
      send_cfg(OTHER_A, 28'h0FF_FFFF, 32'h1111_1111, 32'h2222_3333, ACK_B);
      repeat (3) @(negedge clk);
      chk(ack_n == a0 + 1 && ack_data_last == 32'h5F00_0000, "R3 nack word", ack_data_last, 32'h5F00_0000);
      chk(ack_addr_last == ACK_A, "R3 nack to stored address", ack_addr_last, ACK_A);
      chk(dst_ip_o == 32'hACDC_ABBA && timeout_o == 28'h000_1234, "R3 fields unchanged", dst_ip_o, 32'hACDC_ABBA);

      // R4 R5 R6: table of transmit starts
      for (int v = 0; v < NVEC; v++) begin
         legal = VEC[v][19];
         len   = int'(VEC[v][18:8]);
         tag   = int'(VEC[v][7:0]);
         exph  = legal ? (len + 1) / 2 : 0;
         base  = cap_n; n0 = new_n; a0 = ack_n;
         send_start(legal ? LOCK_A : OTHER_A, len, tag);
         settle(base + exph);
         chk(cap_n - base == exph, "R5 halfword count", cap_n - base, exph);
         bad = 0;
         for (int h = 0; h < exph && base + h < 256; h++)
            if (cap[base + h] != 16'(tag*256 + h)) bad++;
         chk(bad == 0, "R5 low half first order", bad, 0);
         chk(new_n - n0 == int'(legal), "R4 new strobe count", new_n - n0, legal);
         if (legal) chk(new_len_last == 11'(len), "R4 length", new_len_last, len);
         chk(ack_n - a0 == int'(!legal), "R6 nack count", ack_n - a0, !legal);
         if (!legal) chk(ack_data_last == 32'h5F00_0000, "R6 nack word", ack_data_last, 32'h5F00_0000);
      end

      // R1: receive configuration skipped, unknown code ignored, then a start works
      a0 = ack_n; base = cap_n; n0 = new_n;
      put(1'b1, OTHER_A);
      put(1'b0, 32'h3000_0000);
      put(1'b0, 32'h1234_5678);
      put(1'b0, 32'h1000_0000);
      put(1'b0, 32'h0080_ABBA);
      put(1'b1, LOCK_A);
      put(1'b0, 32'h7000_0000);
      send_start(LOCK_A, 2, 40);
      settle(base + 1);
      chk(ack_n == a0, "R1 skipped commands silent", ack_n - a0, 0);
      chk(cap_n - base == 1 && cap[base] == 16'h2800, "R1 following start intact", cap[base], 16'h2800);
      chk(new_n - n0 == 1, "R1 one strobe", new_n - n0, 1);

      // R8 and R4: edge-sensitive reads, stable header before first read
      rd_en = 1'b0; man_re = 1'b0;
      put(1'b1, LOCK_A);
      put(1'b0, hdr(4'h1, 4));
      put(1'b0, {16'h1401, 16'h1400});
      repeat (3) @(negedge clk);
      #2;
      chk(tx_valid_o && tx_data_o == 16'h1400, "R8 first half waiting", tx_data_o, 16'h1400);
      chk(tx_len_o == 11'd4 && dst_ip_o == 32'hACDC_ABBA, "R4 header stable", tx_len_o, 4);
      @(negedge clk); man_re = 1'b1;
      repeat (5) @(negedge clk);
      #2;
      chk(tx_valid_o && tx_data_o == 16'h1401, "R8 held strobe reads one word", tx_data_o, 16'h1401);
      @(negedge clk); man_re = 1'b0;
      repeat (2) @(negedge clk);
      man_re = 1'b1;
      repeat (3) @(negedge clk);
      #2;
      chk(tx_valid_o == 1'b0, "R8 second edge drains", tx_valid_o, 0);
      man_re = 1'b0;
      @(negedge clk);
      rd_en = 1'b1;
      repeat (4) @(negedge clk);

      // R9: waiting acknowledge with full port stalls the bus
      a0 = ack_n;
      @(negedge clk); ack_full_i = 1'b1;
      put(1'b1, OTHER_A);
      put(1'b0, hdr(4'h1, 0));
      repeat (2) @(negedge clk);
      bus_av_i = 1'b1; bus_data_i = LOCK_A; bus_empty_i = 1'b0;
      #2;
      chk(bus_re_o == 1'b0, "R9 read held off", bus_re_o, 0);
      chk(ack_we_o == 1'b0 && ack_n == a0, "R9 no write while full", ack_n - a0, 0);
      @(negedge clk); bus_empty_i = 1'b1; bus_av_i = 1'b0; ack_full_i = 1'b0;
      repeat (2) @(negedge clk);
      #2;
      chk(ack_n == a0 + 1 && ack_data_last == 32'h5F00_0000, "R9 ack released", ack_n - a0, 1);
      chk(bus_re_o == 1'b1, "R9 read resumes", bus_re_o, 1);

      // R7: release from another address has no effect
      put(1'b1, OTHER_A);
      put(1'b0, 32'h2000_0000);
      base = cap_n; n0 = new_n;
      send_start(LOCK_A, 4, 60);
      settle(base + 2);
      chk(new_n - n0 == 1 && cap_n - base == 2, "R7 foreign release ignored", cap_n - base, 2);

      // R7: release from bound address unbinds
      put(1'b1, LOCK_A);
      put(1'b0, 32'h2000_0000);
      base = cap_n; n0 = new_n; a0 = ack_n;
      send_start(LOCK_A, 4, 61);
      settle(base);
      chk(new_n == n0 && cap_n == base, "R7 start after release dropped", cap_n - base, 0);
      chk(ack_n == a0 + 1 && ack_addr_last == ACK_A, "R6 nack after release", ack_addr_last, ACK_A);

      // R2: rebinding to a new address after release
      a0 = ack_n;
      send_cfg(NEW_A, 28'h000_0042, 32'hC0A8_0001, 32'h1388_1389, ACK_B);
      repeat (3) @(negedge clk);
      chk(ack_n == a0 + 1 && ack_addr_last == ACK_B && ack_data_last == 32'h5800_0000,
          "R2 rebind ack", ack_addr_last, ACK_B);
      chk(dst_ip_o == 32'hC0A8_0001 && dst_port_o == 16'h1388 && src_port_o == 16'h1389,
          "R2 rebind fields", dst_ip_o, 32'hC0A8_0001);
      base = cap_n;
      send_start(NEW_A, 3, 70);
      settle(base + 2);
      chk(cap_n - base == 2 && cap[base + 1] == 16'h4601, "R5 odd length new owner", cap[base + 1], 16'h4601);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule